// File: doc/BRIEF.md
# Scoreboard Hazard Tracking Unit

This unit lets a small group of functional units run instructions out of order while a central table guards every data hazard. Each decoded instruction arrives on an issue port. It carries an operation class that names its functional unit, an opcode, one destination register and two source registers. The unit then steps the instruction through four phases in order: issue, operand read, execute and write-back. It grants each phase only when the hazard rule for that phase is met.

Three tables hold the state. Each unit has a status record with its phase, the opcode, the destination, both source numbers, the units that will produce those sources, and a ready flag for each source. A register result table names the unit that will write each register, or marks the register as having no pending writer. Issue is in order and stalls on a busy unit (structural hazard) or on a destination that already has a pending writer (WAW). Operand read waits until both sources are ready (RAW). Write-back waits while an older unread instruction still needs the old value of the destination (WAR). Functional units report completion with a pulse, and the unit broadcasts each write-back to every waiting record.

Top module: `sb_core`

## Requirements
- R1: After reset every unit is idle. No operand-read or write-back grant is raised, and each unit's opcode output reads zero.
- R2: A request is refused (issue grant low in the same cycle) while its operation class selects a unit that holds an unfinished instruction. Class value k selects unit k.
- R3: A request is refused while its destination register already has a pending writer (WAW).
- R4: An instruction gets no operand-read grant while either source is awaited from a producer that has not yet written back (RAW).
- R5: An instruction issued with no hazard receives its operand-read grant in the cycle after issue, for exactly one cycle.
- R6: A completion pulse from a unit that has read its operands produces that unit's write-back grant in the next cycle when no WAR hazard exists. Each instruction receives exactly one write-back grant.
- R7: A write-back is held while an older instruction that has not read its operands names the destination as a source whose ready flag is set. It is released in the cycle after that reader's operand-read grant.
- R8: At most one write-back grant is raised per cycle. Among units ready at once, the lowest-numbered unit wins and the others follow in later cycles.
- R9: In the cycle after a write-back grant, the unit accepts a new instruction, and the written register no longer blocks issue.
- R10: A unit's opcode output shows the opcode of the instruction it holds from the cycle after issue.
- R11: A source whose producer writes back in the same cycle the consumer issues counts as ready, so the consumer's operand-read grant follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid_i | input | 1 | Issue request present |
| iss_class_i | input | FU_W | Operation class, which is the index of the target unit |
| iss_op_i | input | OP_W | Opcode stored for the unit |
| iss_dst_i | input | REG_W | Destination register |
| iss_src1_i | input | REG_W | First source register |
| iss_src2_i | input | REG_W | Second source register |
| iss_grant_o | output | 1 | Issue accepted this cycle (combinational) |
| rd_grant_o | output | NUM_FU | Per-unit operand-read grant |
| exec_done_i | input | NUM_FU | Per-unit execution-finished pulse |
| wb_grant_o | output | NUM_FU | Per-unit write-back grant, at most one bit set |
| fu_op_o | output | NUM_FU*OP_W | Opcode held by each unit |

## Verification
The issue grant is combinational, so the bench checks it in the same cycle the request is driven. Operand-read grants appear one cycle after the issue or write-back that made both sources ready. Write-back grants appear one cycle after the completion pulse, or one cycle after the blocking reader is granted. For each stimulus, the driver records the exact cycle each grant is due together with its expected per-unit vector. The monitor samples on the falling edge of that cycle and compares the whole vector, so an early grant, a late grant or a grant to the wrong unit is reported as a mismatch.

// File: rtl/sb_pkg.sv
package sb_pkg;

    // Lifecycle of the instruction held by one functional unit.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_WAIT_RD = 2'd1,
        PH_EXEC    = 2'd2,
        PH_WAIT_WB = 2'd3
    } sb_phase_e;

endpackage

// File: rtl/sb_issue_gate.sv
module sb_issue_gate #(
    parameter int NUM_FU   = 4,
    parameter int NUM_REGS = 8,
    parameter int FU_W     = 2,
    parameter int REG_W    = 3
) (
    input  logic                iss_valid_i,
    input  logic [FU_W-1:0]     iss_class_i,
    input  logic [REG_W-1:0]    iss_dst_i,
    input  logic [NUM_FU-1:0]   busy_v_i,
    input  logic [NUM_REGS-1:0] pend_v_i,
    output logic                grant_o
);
    // Structural hazard: target unit occupied. WAW: destination already owned.
    assign grant_o = iss_valid_i && !busy_v_i[iss_class_i] && !pend_v_i[iss_dst_i];
endmodule

// File: rtl/sb_war_check.sv
module sb_war_check #(
    parameter int NUM_FU = 4,
    parameter int REG_W  = 3
) (
    input  logic [NUM_FU-1:0]             wait_v_i,
    input  logic [NUM_FU-1:0]             rj_v_i,
    input  logic [NUM_FU-1:0]             rk_v_i,
    input  logic [NUM_FU-1:0][REG_W-1:0]  fi_a_i,
    input  logic [NUM_FU-1:0][REG_W-1:0]  fj_a_i,
    input  logic [NUM_FU-1:0][REG_W-1:0]  fk_a_i,
    output logic [NUM_FU-1:0]             war_ok_o
);
    for (genvar u = 0; u < NUM_FU; u++) begin : g_wr
        logic [NUM_FU-1:0] blk;
        for (genvar f = 0; f < NUM_FU; f++) begin : g_rd
            if (f == u) begin : g_self
                assign blk[f] = 1'b0;
            end else begin : g_other
                // an unread reader still wants the old value of our destination
                assign blk[f] = wait_v_i[f] &&
                                ((fj_a_i[f] == fi_a_i[u] && rj_v_i[f]) ||
                                 (fk_a_i[f] == fi_a_i[u] && rk_v_i[f]));
            end
        end
        assign war_ok_o[u] = ~|blk;
    end
endmodule

// File: rtl/sb_wb_arbiter.sv
module sb_wb_arbiter #(
    parameter int NUM_FU = 4
) (
    input  logic [NUM_FU-1:0] req_i,
    output logic [NUM_FU-1:0] grant_o
);
    // isolate the lowest set bit
    assign grant_o = req_i & (~req_i + 1'b1);
endmodule

// File: rtl/sb_core.sv
module sb_core #(
    parameter  int NUM_FU   = 4,
    parameter  int NUM_REGS = 8,
    parameter  int OP_W     = 3,
    localparam int FU_W     = (NUM_FU > 1) ? $clog2(NUM_FU) : 1,
    localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iss_valid_i,
    input  logic [FU_W-1:0]        iss_class_i,
    input  logic [OP_W-1:0]        iss_op_i,
    input  logic [REG_W-1:0]       iss_dst_i,
    input  logic [REG_W-1:0]       iss_src1_i,
    input  logic [REG_W-1:0]       iss_src2_i,
    output logic                   iss_grant_o,
    output logic [NUM_FU-1:0]      rd_grant_o,
    input  logic [NUM_FU-1:0]      exec_done_i,
    output logic [NUM_FU-1:0]      wb_grant_o,
    output logic [NUM_FU*OP_W-1:0] fu_op_o
);
    import sb_pkg::*;

    typedef struct packed {
        sb_phase_e        ph;
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] fi;
        logic [REG_W-1:0] fj;
        logic [REG_W-1:0] fk;
        logic [FU_W-1:0]  qj;
        logic [FU_W-1:0]  qk;
        logic             rj;
        logic             rk;
    } fu_stat_t;

    typedef struct packed {
        logic            vld;
        logic [FU_W-1:0] fu;
    } rt_ent_t;

    typedef struct packed {
        fu_stat_t [NUM_FU-1:0] fu;
        rt_ent_t  [NUM_REGS-1:0] rt;
    } sb_state_t;

    sb_state_t st_d, st_q;

    logic [NUM_FU-1:0]            busy_v, wait_v, rj_v, rk_v, war_ok, wb_req;
    logic [NUM_REGS-1:0]          pend_v;
    logic [NUM_FU-1:0][REG_W-1:0] fi_a, fj_a, fk_a;

    for (genvar u = 0; u < NUM_FU; u++) begin : g_flat
        assign busy_v[u] = (st_q.fu[u].ph != PH_IDLE);
        assign wait_v[u] = (st_q.fu[u].ph == PH_WAIT_RD);
        assign rj_v[u]   = st_q.fu[u].rj;
        assign rk_v[u]   = st_q.fu[u].rk;
        assign fi_a[u]   = st_q.fu[u].fi;
        assign fj_a[u]   = st_q.fu[u].fj;
        assign fk_a[u]   = st_q.fu[u].fk;
        assign rd_grant_o[u] = wait_v[u] && st_q.fu[u].rj && st_q.fu[u].rk;
        assign wb_req[u]     = (st_q.fu[u].ph == PH_WAIT_WB) && war_ok[u];
        assign fu_op_o[u*OP_W +: OP_W] = st_q.fu[u].op;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_pend
        assign pend_v[r] = st_q.rt[r].vld;
    end

    sb_issue_gate #(
        .NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS), .FU_W(FU_W), .REG_W(REG_W)
    ) issue_gate_i (
        .iss_valid_i(iss_valid_i), .iss_class_i(iss_class_i), .iss_dst_i(iss_dst_i),
        .busy_v_i(busy_v), .pend_v_i(pend_v), .grant_o(iss_grant_o)
    );

    sb_war_check #(.NUM_FU(NUM_FU), .REG_W(REG_W)) war_check_i (
        .wait_v_i(wait_v), .rj_v_i(rj_v), .rk_v_i(rk_v),
        .fi_a_i(fi_a), .fj_a_i(fj_a), .fk_a_i(fk_a), .war_ok_o(war_ok)
    );

    sb_wb_arbiter #(.NUM_FU(NUM_FU)) wb_arb_i (
        .req_i(wb_req), .grant_o(wb_grant_o)
    );

    always_comb begin
        rt_ent_t e1, e2;
        st_d = st_q;
        // operand read and execution progress
        for (int u = 0; u < NUM_FU; u++) begin
            if (rd_grant_o[u]) begin
                st_d.fu[u].ph = PH_EXEC;
                st_d.fu[u].rj = 1'b0;
                st_d.fu[u].rk = 1'b0;
            end else if (st_q.fu[u].ph == PH_EXEC && exec_done_i[u]) begin
                st_d.fu[u].ph = PH_WAIT_WB;
            end
        end
        // write-back: release unit and register, wake up waiting readers
        for (int u = 0; u < NUM_FU; u++) begin
            if (wb_grant_o[u]) begin
                st_d.fu[u].ph = PH_IDLE;
                st_d.rt[st_q.fu[u].fi].vld = 1'b0;
                for (int f = 0; f < NUM_FU; f++) begin
                    if (st_q.fu[f].ph == PH_WAIT_RD) begin
                        if (!st_q.fu[f].rj && st_q.fu[f].qj == FU_W'(u)) st_d.fu[f].rj = 1'b1;
                        if (!st_q.fu[f].rk && st_q.fu[f].qk == FU_W'(u)) st_d.fu[f].rk = 1'b1;
                    end
                end
            end
        end
        // issue
        e1 = st_q.rt[iss_src1_i];
        e2 = st_q.rt[iss_src2_i];
        if (iss_grant_o) begin
            st_d.fu[iss_class_i].ph = PH_WAIT_RD;
            st_d.fu[iss_class_i].op = iss_op_i;
            st_d.fu[iss_class_i].fi = iss_dst_i;
            st_d.fu[iss_class_i].fj = iss_src1_i;
            st_d.fu[iss_class_i].fk = iss_src2_i;
            st_d.fu[iss_class_i].qj = e1.fu;
            st_d.fu[iss_class_i].qk = e2.fu;
            st_d.fu[iss_class_i].rj = !(e1.vld && !wb_grant_o[e1.fu]);
            st_d.fu[iss_class_i].rk = !(e2.vld && !wb_grant_o[e2.fu]);
            st_d.rt[iss_dst_i].vld  = 1'b1;
            st_d.rt[iss_dst_i].fu   = iss_class_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    wb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant_o));

    // R2
    no_reissue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid_i && iss_grant_o) |=>
        !(iss_valid_i && iss_grant_o && (iss_class_i == $past(iss_class_i))));

    for (genvar u = 0; u < NUM_FU; u++) begin : g_chk
        // R5
        rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rd_grant_o[u] |=> !rd_grant_o[u]);
        // R6
        wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wb_grant_o[u] |=> !wb_grant_o[u]);
    end

endmodule

// File: tb/sb_core_tb.sv
module sb_core_tb_top;
    localparam int NUM_FU = 4;
    localparam int NUM_REGS = 8;
    localparam int OP_W = 3;
    localparam int K_ISS = 0, K_RD = 1, K_WB = 2, K_OP = 3;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   iss_valid_i = 1'b0;
    logic [1:0]             iss_class_i = '0;
    logic [OP_W-1:0]        iss_op_i = '0;
    logic [2:0]             iss_dst_i = '0, iss_src1_i = '0, iss_src2_i = '0;
    logic                   iss_grant_o;
    logic [NUM_FU-1:0]      rd_grant_o, wb_grant_o;
    logic [NUM_FU-1:0]      exec_done_i = '0;
    logic [NUM_FU*OP_W-1:0] fu_op_o;

    always #2 clk = ~clk;   // 250 MHz

    sb_core #(.NUM_FU(NUM_FU), .NUM_REGS(NUM_REGS), .OP_W(OP_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid_i(iss_valid_i), .iss_class_i(iss_class_i),
        .iss_op_i(iss_op_i), .iss_dst_i(iss_dst_i), .iss_src1_i(iss_src1_i),
        .iss_src2_i(iss_src2_i), .iss_grant_o(iss_grant_o), .rd_grant_o(rd_grant_o),
        .exec_done_i(exec_done_i), .wb_grant_o(wb_grant_o), .fu_op_o(fu_op_o)
    );

    typedef struct {
        int         cyc;
        int         kind;
        int         unit;
        logic [7:0] val;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t e;
    logic [7:0] act;
    int cyc = 0;
    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // monitor: compare every expectation due in the current cycle
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = exp_q.size() - 1; i >= 0; i--) begin
                if (exp_q[i].cyc == cyc) begin
                    e = exp_q[i];
                    case (e.kind)
                        K_ISS:   act = {7'd0, iss_grant_o};
                        K_RD:    act = {4'd0, rd_grant_o};
                        K_WB:    act = {4'd0, wb_grant_o};
                        default: act = {5'd0, fu_op_o[e.unit*OP_W +: OP_W]};
                    endcase
                    n_chk++;
                    if (act !== e.val) begin
                        n_err++;
                        $display("FAIL %s cycle %0d kind %0d: actual=%b expected=%b",
                                 e.tag, cyc, e.kind, act, e.val);
                    end
                    exp_q.delete(i);
                end
            end
        end
    end

    task automatic expect_at(int c, int kind, int unit, logic [7:0] v, string tag);
        exp_t x;
        x.cyc = c; x.kind = kind; x.unit = unit; x.val = v; x.tag = tag;
        exp_q.push_back(x);
    endtask

    // advance to the next cycle window and clear pulse inputs
    task automatic step();
        @(posedge clk);
        #1;
        iss_valid_i = 1'b0;
        exec_done_i = '0;
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic drive_issue(int cls, int op, int d, int s1, int s2);
        iss_valid_i = 1'b1;
        iss_class_i = 2'(cls);
        iss_op_i    = OP_W'(op);
        iss_dst_i   = 3'(d);
        iss_src1_i  = 3'(s1);
        iss_src2_i  = 3'(s2);
    endtask

    int w;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        step();
        // R1: reset state
        expect_at(cyc, K_RD, 0, 8'h0, "R1");
        expect_at(cyc, K_WB, 0, 8'h0, "R1");
        expect_at(cyc, K_OP, 0, 8'h0, "R1");
        step();

        // Scene A: basic flow, re-issue after write-back
        w = cyc;
        drive_issue(0, 5, 1, 2, 3);
        expect_at(w, K_ISS, 0, 8'h1, "R5");
        expect_at(w + 1, K_RD, 0, 8'h1, "R5");
        expect_at(w + 1, K_OP, 0, 8'h5, "R10");
        expect_at(w + 2, K_RD, 0, 8'h0, "R5");
        expect_at(w + 3, K_WB, 0, 8'h1, "R6");
        expect_at(w + 4, K_WB, 0, 8'h0, "R6");
        step(); step();
        exec_done_i = 4'b0001;
        steps(2);
        drive_issue(0, 2, 1, 0, 0);
        expect_at(cyc, K_ISS, 0, 8'h1, "R9");
        expect_at(cyc + 1, K_RD, 0, 8'h1, "R5");
        step(); step();
        exec_done_i = 4'b0001;
        expect_at(cyc + 1, K_WB, 0, 8'h1, "R6");
        steps(3);

        // Scene B: structural and WAW stalls
        w = cyc;
        drive_issue(1, 1, 4, 0, 0);
        expect_at(w, K_ISS, 0, 8'h1, "R2");
        step();
        drive_issue(1, 1, 5, 0, 0);
        expect_at(w + 1, K_ISS, 0, 8'h0, "R2");
        expect_at(w + 1, K_RD, 0, 8'h2, "R5");
        step();
        drive_issue(2, 1, 4, 0, 0);
        expect_at(w + 2, K_ISS, 0, 8'h0, "R3");
        step();
        exec_done_i = 4'b0010;
        expect_at(w + 4, K_WB, 0, 8'h2, "R6");
        steps(2);
        drive_issue(2, 3, 4, 0, 0);
        expect_at(w + 5, K_ISS, 0, 8'h1, "R9");
        expect_at(w + 6, K_RD, 0, 8'h4, "R5");
        steps(2);
        exec_done_i = 4'b0100;
        expect_at(w + 8, K_WB, 0, 8'h4, "R6");
        steps(3);

        // Scene C: RAW wait
        w = cyc;
        drive_issue(0, 1, 2, 0, 0);
        step();
        drive_issue(1, 1, 3, 2, 0);
        expect_at(w + 1, K_ISS, 0, 8'h1, "R4");
        expect_at(w + 1, K_RD, 0, 8'h1, "R4");
        expect_at(w + 2, K_RD, 0, 8'h0, "R4");
        expect_at(w + 3, K_RD, 0, 8'h0, "R4");
        expect_at(w + 3, K_WB, 0, 8'h1, "R4");
        expect_at(w + 4, K_RD, 0, 8'h2, "R4");
        step();
        exec_done_i = 4'b0001;
        steps(3);
        exec_done_i = 4'b0010;
        expect_at(w + 6, K_WB, 0, 8'h2, "R6");
        steps(3);

        // Scene D: WAR hold
        w = cyc;
        drive_issue(0, 1, 6, 0, 0);
        step();
        drive_issue(1, 4, 7, 5, 6);
        expect_at(w + 1, K_RD, 0, 8'h1, "R7");
        step();
        drive_issue(2, 1, 5, 0, 0);
        expect_at(w + 2, K_ISS, 0, 8'h1, "R7");
        expect_at(w + 2, K_RD, 0, 8'h0, "R4");
        expect_at(w + 3, K_RD, 0, 8'h4, "R7");
        step(); step();
        exec_done_i = 4'b0100;
        step();
        exec_done_i = 4'b0001;
        expect_at(w + 5, K_WB, 0, 8'h0, "R7");
        expect_at(w + 6, K_WB, 0, 8'h1, "R7");
        expect_at(w + 7, K_RD, 0, 8'h2, "R4");
        expect_at(w + 7, K_WB, 0, 8'h0, "R7");
        expect_at(w + 8, K_WB, 0, 8'h4, "R7");
        expect_at(w + 9, K_WB, 0, 8'h2, "R6");
        steps(3);
        exec_done_i = 4'b0010;
        steps(3);

        // Scene E: simultaneous completions, priority
        w = cyc;
        drive_issue(3, 6, 1, 0, 0);
        step();
        drive_issue(2, 2, 2, 0, 0);
        expect_at(w + 1, K_RD, 0, 8'h8, "R5");
        expect_at(w + 1, K_OP, 3, 8'h6, "R10");
        expect_at(w + 2, K_RD, 0, 8'h4, "R5");
        steps(2);
        exec_done_i = 4'b1100;
        expect_at(w + 4, K_WB, 0, 8'h4, "R8");
        expect_at(w + 5, K_WB, 0, 8'h8, "R8");
        expect_at(w + 6, K_WB, 0, 8'h0, "R8");
        steps(4);

        // Scene F: same-cycle write-back satisfies a new consumer
        w = cyc;
        drive_issue(0, 1, 3, 0, 0);
        expect_at(w + 1, K_RD, 0, 8'h1, "R5");
        steps(2);
        exec_done_i = 4'b0001;
        step();
        drive_issue(1, 7, 4, 3, 0);
        expect_at(w + 3, K_WB, 0, 8'h1, "R11");
        expect_at(w + 3, K_ISS, 0, 8'h1, "R11");
        expect_at(w + 4, K_RD, 0, 8'h2, "R11");
        steps(2);
        exec_done_i = 4'b0010;
        expect_at(w + 6, K_WB, 0, 8'h2, "R11");
        steps(4);

        if (exp_q.size() != 0) begin
            n_chk++;
            n_err++;
            $display("FAIL pending expectations left: actual=%0d expected=0", exp_q.size());
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule